// File: doc/BRIEF.md
# Windowed Flow-Control Calendar Table

This block stores the flow-control calendars of a multi-channel packet link: one table for the transmit direction and one for the receive direction, each 288 slots deep. A slot carries a 2-bit control code and an 8-bit pipe or backpressure ID. The code marks the slot as link-level status, as a channel bound to that ID, or as forced XON or forced XOFF. Slots are grouped 16 at a time. The first slot of each group is reserved for link status and the other fifteen carry channels, so channel numbers map onto slot numbers with gaps.

Software reaches a table through one access port. An index register picks one of 36 windows of eight slots. Two 64-bit data words expose the window, with four slots in each word. When auto-increment is on, writing the upper word moves the index on, so a whole table can be filled by streaming writes. A fourth address takes a channel number and an ID. The block computes the slot for that channel, loads it, and marks the group's link slot when the window requires it. A scanner walks both tables together, one slot per enable pulse, over a programmable round length. It presents the current slot's code and ID for each direction.

Top module: `cal_window_table`

## Requirements
- R1: After reset, and in the cycle after a `clr` pulse, every transmit slot holds code 3 (XOFF) and every receive slot holds code 2 (XON), all IDs read 0, and `cfg_err` is 0. The index and auto-increment bit of each table are left unchanged by `clr`.
- R2: Control codes are 0 channel, 1 link, 2 XON and 3 XOFF. In a data word, lane k (0..3) holds the slot ID in bits [16k+7:16k] and the code in bits [16k+9:16k+8]. The other bits read 0 and are dropped on write. Word 0 (address 1) holds window positions 0..3 and word 1 (address 2) holds positions 4..7.
- R3: Address 0 is the index register. Bits [7:0] hold the window number and bit 8 is auto-increment. A read returns the stored window and bit.
- R4: Writing a window number above 35 stores 35 and sets `cfg_err`. The flag stays set until `clr`.
- R5: A data-word write updates only the four slots of the indexed window in that word, in the table chosen by `acc_tbl`. A read returns the window's current contents and leaves the index where it was.
- R6: With auto-increment set, a word-1 write moves the index to the next window, and window 35 wraps to 0. A word-0 write never moves the index.
- R7: A write to address 3 with channel c in bits [8:0] and ID in bits [23:16] sets slot 1 + c + floor(c/15) to code 0 with that ID. If that slot's window (slot/8) is even, position 0 of the window takes code 1 and keeps its ID. The index does not move.
- R8: A channel command with c of 270 or more changes no slot and sets `cfg_err`.
- R9: `acc_tbl` = 0 selects the transmit table and 1 selects the receive table. The other table is not touched.
- R10: `scan_slot` advances by one on each `scan_en` cycle. Once it reaches the round length minus 1, the next step returns it to 0. A `scan_len` of 0 or above 288 means 288. `scan_round` is high while the slot is 0. The slot outputs show each table's code and ID at `scan_slot`.
- R11: A read returns `acc_rdata` with a one-cycle `acc_rvalid` pulse in the cycle after the request. Address 3 reads as 0.
- R12: An access issued in a cycle where `clr` is high is dropped: no write takes effect and no read data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Returns both tables to their cleared contents |
| acc_en | input | 1 | Access request |
| acc_wr | input | 1 | 1 write, 0 read |
| acc_tbl | input | 1 | Table select: 0 transmit, 1 receive |
| acc_addr | input | 2 | 0 index, 1 word 0, 2 word 1, 3 channel command |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data |
| acc_rvalid | output | 1 | Read data valid |
| cfg_err | output | 1 | Sticky error for an out-of-range index or channel |
| scan_en | input | 1 | Scanner step |
| scan_len | input | 10 | Round length in slots |
| scan_slot | output | 9 | Current scanner slot |
| scan_round | output | 1 | High at slot 0 |
| tx_slot_ctl | output | 2 | Transmit code at the scanner slot |
| tx_slot_id | output | 8 | Transmit ID at the scanner slot |
| rx_slot_ctl | output | 2 | Receive code at the scanner slot |
| rx_slot_id | output | 8 | Receive ID at the scanner slot |

## Verification
The bench targets the channel-to-slot arithmetic across a group boundary (channels 14, 15 and 269) and the link-slot marking that only even windows receive. A wrong divisor or a missing gap would leave the ID one slot off, and marking odd windows would corrupt slot 8 of a group. It streams writes through window 35 to check the index wrap and the saturation of oversized index values. An off-by-one there would either overrun the table or stall the index. It also checks that a word-0 write does not advance the index, that `clr` drops an access issued in the same cycle, and that the scanner wraps at both a short length and the default full length. A scanner that compares with the wrong bound would either skip the last slot or run one slot past it.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int CTL_W = 2;

  typedef enum logic [CTL_W-1:0] {
    CTL_CHAN = 2'd0,
    CTL_LINK = 2'd1,
    CTL_XON  = 2'd2,
    CTL_XOFF = 2'd3
  } cal_ctl_e;

  localparam logic [1:0] ADDR_INDEX = 2'd0;
  localparam logic [1:0] ADDR_WORD0 = 2'd1;
  localparam logic [1:0] ADDR_WORD1 = 2'd2;
  localparam logic [1:0] ADDR_CHAN  = 2'd3;

  // Slot holding channel c when each group of `group` slots starts with a link slot.
  function automatic int chan_slot(input int chan, input int group);
    return 1 + chan + chan / (group - 1);
  endfunction

  function automatic int sat_window(input int req, input int windows);
    return (req > windows - 1) ? windows - 1 : req;
  endfunction

  function automatic int next_window(input int cur, input int windows);
    return (cur == windows - 1) ? 0 : cur + 1;
  endfunction

  function automatic int eff_round(input int len, input int entries);
    return (len == 0 || len > entries) ? entries : len;
  endfunction

endpackage

// File: rtl/cal_locate.sv
module cal_locate #(
  parameter int ENTRIES = 288,
  parameter int WIN_ENT = 8,
  parameter int GROUP   = 16,
  parameter int CHAN_W  = 9,
  localparam int ENT_W  = $clog2(ENTRIES),
  localparam int MAX_CHAN = (ENTRIES / GROUP) * (GROUP - 1)
) (
  input  logic [CHAN_W-1:0] chan_i,
  output logic [ENT_W-1:0]  slot_o,
  output logic [ENT_W-1:0]  link_slot_o,
  output logic              force_link_o,
  output logic              chan_ok_o
);
  import cal_pkg::*;

  int slot_n;
  int win_n;

  always_comb begin
    slot_n       = chan_slot(int'(chan_i), GROUP);
    win_n        = slot_n / WIN_ENT;
    chan_ok_o    = int'(chan_i) < MAX_CHAN;
    slot_o       = chan_ok_o ? ENT_W'(slot_n) : '0;
    link_slot_o  = chan_ok_o ? ENT_W'(win_n * WIN_ENT) : '0;
    force_link_o = chan_ok_o && ((win_n % 2) == 0);
  end

endmodule

// File: rtl/cal_table.sv
module cal_table #(
  parameter int ENTRIES = 288,
  parameter int WIN_ENT = 8,
  parameter int ID_W    = 8,
  parameter int DATA_W  = 64,
  parameter int SLOT_W  = 16,
  parameter cal_pkg::cal_ctl_e CLEAR_CTL = cal_pkg::CTL_XOFF,
  localparam int WINDOWS  = ENTRIES / WIN_ENT,
  localparam int WIN_W    = $clog2(WINDOWS),
  localparam int ENT_W    = $clog2(ENTRIES),
  localparam int PER_WORD = WIN_ENT / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              idx_wr_i,
  input  logic [WIN_W-1:0]  idx_win_i,
  input  logic              idx_ainc_i,
  input  logic              word_wr_i,
  input  logic              word_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ch_wr_i,
  input  logic [ENT_W-1:0]  ch_slot_i,
  input  logic [ENT_W-1:0]  ch_link_i,
  input  logic              ch_force_i,
  input  logic [ID_W-1:0]   ch_id_i,
  input  logic [ENT_W-1:0]  scan_slot_i,
  output logic [WIN_W-1:0]  win_o,
  output logic              ainc_o,
  output logic [DATA_W-1:0] word0_o,
  output logic [DATA_W-1:0] word1_o,
  output logic [1:0]        scan_ctl_o,
  output logic [ID_W-1:0]   scan_id_o
);
  import cal_pkg::*;

  logic [CTL_W-1:0] ctl_q [ENTRIES];
  logic [ID_W-1:0]  id_q  [ENTRIES];
  logic [WIN_W-1:0] win_q;
  logic             ainc_q;

  // Index register: explicit load, or step after the upper word is written.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      ainc_q <= 1'b0;
    end else if (idx_wr_i) begin
      win_q  <= idx_win_i;
      ainc_q <= idx_ainc_i;
    end else if (word_wr_i && word_hi_i && ainc_q) begin
      win_q  <= WIN_W'(next_window(int'(win_q), WINDOWS));
    end
  end

  // Slot storage: clear beats window write, which beats channel update.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ctl_q[i] <= CLEAR_CTL;
        id_q[i]  <= '0;
      end
    end else if (clr_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ctl_q[i] <= CLEAR_CTL;
        id_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (word_wr_i && (i / WIN_ENT) == int'(win_q) &&
            ((i % WIN_ENT) / PER_WORD) == int'(word_hi_i)) begin
          ctl_q[i] <= wdata_i[(i % PER_WORD) * SLOT_W + ID_W +: CTL_W];
          id_q[i]  <= wdata_i[(i % PER_WORD) * SLOT_W +: ID_W];
        end else if (ch_wr_i && i == int'(ch_slot_i)) begin
          ctl_q[i] <= CTL_CHAN;
          id_q[i]  <= ch_id_i;
        end else if (ch_wr_i && ch_force_i && i == int'(ch_link_i)) begin
          ctl_q[i] <= CTL_LINK;
        end
      end
    end
  end

  // Window view: two words of PER_WORD lanes each.
  always_comb begin
    word0_o = '0;
    word1_o = '0;
    for (int p = 0; p < PER_WORD; p++) begin
      word0_o[p * SLOT_W +: ID_W]         = id_q[int'(win_q) * WIN_ENT + p];
      word0_o[p * SLOT_W + ID_W +: CTL_W] = ctl_q[int'(win_q) * WIN_ENT + p];
      word1_o[p * SLOT_W +: ID_W]         = id_q[int'(win_q) * WIN_ENT + PER_WORD + p];
      word1_o[p * SLOT_W + ID_W +: CTL_W] = ctl_q[int'(win_q) * WIN_ENT + PER_WORD + p];
    end
  end

  assign win_o      = win_q;
  assign ainc_o     = ainc_q;
  assign scan_ctl_o = ctl_q[scan_slot_i];
  assign scan_id_o  = id_q[scan_slot_i];

endmodule

// File: rtl/cal_scan.sv
module cal_scan #(
  parameter int ENTRIES = 288,
  localparam int ENT_W  = $clog2(ENTRIES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_i,
  input  logic [ENT_W:0] len_i,
  output logic [ENT_W-1:0] slot_o,
  output logic           round_o,
  output logic [ENT_W:0] eff_len_o,
  output logic           wrap_o
);
  import cal_pkg::*;

  logic [ENT_W-1:0] slot_q;

  assign eff_len_o = (ENT_W+1)'(eff_round(int'(len_i), ENTRIES));
  // >= keeps the slot in range even if the length shrinks mid-round
  assign wrap_o    = step_i && (int'(slot_q) + 1 >= int'(eff_len_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slot_q <= '0;
    else if (wrap_o)  slot_q <= '0;
    else if (step_i)  slot_q <= slot_q + 1'b1;
  end

  assign slot_o  = slot_q;
  assign round_o = (slot_q == '0);

endmodule

// File: rtl/cal_window_table.sv
module cal_window_table #(
  parameter int ENTRIES  = 288,
  parameter int WIN_ENT  = 8,
  parameter int GROUP    = 16,
  parameter int ID_W     = 8,
  parameter int DATA_W   = 64,
  parameter int SLOT_W   = 16,
  parameter int AINC_BIT = 8,
  parameter int CH_ID_LSB = 16,
  localparam int WINDOWS = ENTRIES / WIN_ENT,
  localparam int WIN_W   = $clog2(WINDOWS),
  localparam int ENT_W   = $clog2(ENTRIES),
  localparam int CHAN_W  = ENT_W,
  localparam int NUM_TBL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_tbl,
  input  logic [1:0]        acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_rvalid,
  output logic              cfg_err,
  input  logic              scan_en,
  input  logic [ENT_W:0]    scan_len,
  output logic [ENT_W-1:0]  scan_slot,
  output logic              scan_round,
  output logic [1:0]        tx_slot_ctl,
  output logic [ID_W-1:0]   tx_slot_id,
  output logic [1:0]        rx_slot_ctl,
  output logic [ID_W-1:0]   rx_slot_id
);
  import cal_pkg::*;

  // Named events used by the checker.
  logic wr_go, rd_go;
  logic ev_idx_wr, ev_word_wr, ev_chan_wr;
  logic ev_idx_ovf, ev_chan_bad;
  logic ev_w1_wr [NUM_TBL];
  logic scan_wrap;
  logic [ENT_W:0] scan_eff_len;

  logic [WIN_W-1:0]  idx_sat;
  logic [ENT_W-1:0]  ch_slot, ch_link;
  logic              ch_force, ch_ok;

  logic [WIN_W-1:0]  tbl_win   [NUM_TBL];
  logic              tbl_ainc  [NUM_TBL];
  logic [DATA_W-1:0] tbl_word0 [NUM_TBL];
  logic [DATA_W-1:0] tbl_word1 [NUM_TBL];
  logic [1:0]        tbl_sctl  [NUM_TBL];
  logic [ID_W-1:0]   tbl_sid   [NUM_TBL];

  logic [DATA_W-1:0] rd_mux;
  logic              err_q;

  assign wr_go = acc_en && acc_wr && !clr;
  assign rd_go = acc_en && !acc_wr && !clr;

  assign idx_sat = WIN_W'(sat_window(int'(acc_wdata[AINC_BIT-1:0]), WINDOWS));

  assign ev_idx_wr   = wr_go && acc_addr == ADDR_INDEX;
  assign ev_word_wr  = wr_go && (acc_addr == ADDR_WORD0 || acc_addr == ADDR_WORD1);
  assign ev_chan_wr  = wr_go && acc_addr == ADDR_CHAN && ch_ok;
  assign ev_idx_ovf  = ev_idx_wr && int'(acc_wdata[AINC_BIT-1:0]) > WINDOWS - 1;
  assign ev_chan_bad = wr_go && acc_addr == ADDR_CHAN && !ch_ok;

  cal_locate #(
    .ENTRIES (ENTRIES),
    .WIN_ENT (WIN_ENT),
    .GROUP   (GROUP),
    .CHAN_W  (CHAN_W)
  ) u_locate (
    .chan_i       (acc_wdata[CHAN_W-1:0]),
    .slot_o       (ch_slot),
    .link_slot_o  (ch_link),
    .force_link_o (ch_force),
    .chan_ok_o    (ch_ok)
  );

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    logic sel;
    assign sel = (acc_tbl == 1'(t));
    assign ev_w1_wr[t] = ev_word_wr && sel && acc_addr == ADDR_WORD1;

    cal_table #(
      .ENTRIES   (ENTRIES),
      .WIN_ENT   (WIN_ENT),
      .ID_W      (ID_W),
      .DATA_W    (DATA_W),
      .SLOT_W    (SLOT_W),
      .CLEAR_CTL ((t == 0) ? CTL_XOFF : CTL_XON)
    ) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (clr),
      .idx_wr_i    (ev_idx_wr && sel),
      .idx_win_i   (idx_sat),
      .idx_ainc_i  (acc_wdata[AINC_BIT]),
      .word_wr_i   (ev_word_wr && sel),
      .word_hi_i   (acc_addr == ADDR_WORD1),
      .wdata_i     (acc_wdata),
      .ch_wr_i     (ev_chan_wr && sel),
      .ch_slot_i   (ch_slot),
      .ch_link_i   (ch_link),
      .ch_force_i  (ch_force),
      .ch_id_i     (acc_wdata[CH_ID_LSB +: ID_W]),
      .scan_slot_i (scan_slot),
      .win_o       (tbl_win[t]),
      .ainc_o      (tbl_ainc[t]),
      .word0_o     (tbl_word0[t]),
      .word1_o     (tbl_word1[t]),
      .scan_ctl_o  (tbl_sctl[t]),
      .scan_id_o   (tbl_sid[t])
    );
  end

  cal_scan #(.ENTRIES(ENTRIES)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (scan_en),
    .len_i     (scan_len),
    .slot_o    (scan_slot),
    .round_o   (scan_round),
    .eff_len_o (scan_eff_len),
    .wrap_o    (scan_wrap)
  );

  always_comb begin
    rd_mux = '0;
    case (acc_addr)
      ADDR_INDEX: begin
        rd_mux[WIN_W-1:0] = tbl_win[acc_tbl];
        rd_mux[AINC_BIT]  = tbl_ainc[acc_tbl];
      end
      ADDR_WORD0: rd_mux = tbl_word0[acc_tbl];
      ADDR_WORD1: rd_mux = tbl_word1[acc_tbl];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_rdata  <= '0;
      acc_rvalid <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      acc_rvalid <= rd_go;
      if (rd_go) acc_rdata <= rd_mux;
      if (clr)                            err_q <= 1'b0;
      else if (ev_idx_ovf || ev_chan_bad) err_q <= 1'b1;
    end
  end

  assign cfg_err     = err_q;
  assign tx_slot_ctl = tbl_sctl[0];
  assign tx_slot_id  = tbl_sid[0];
  assign rx_slot_ctl = tbl_sctl[1];
  assign rx_slot_id  = tbl_sid[1];

endmodule

// File: rtl/cal_window_table_chk.sv
module cal_window_table_chk #(
  parameter int WINDOWS = 36,
  parameter int WIN_W   = 6,
  parameter int ENTRIES = 288,
  parameter int ENT_W   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             acc_en,
  input logic             acc_wr,
  input logic             acc_rvalid,
  input logic             cfg_err,
  input logic             ev_idx_ovf,
  input logic             ev_chan_bad,
  input logic             tx_w1,
  input logic             tx_ainc,
  input logic [WIN_W-1:0] tx_win,
  input logic [WIN_W-1:0] rx_win,
  input logic             scan_en,
  input logic [ENT_W-1:0] scan_slot,
  input logic             scan_wrap
);

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_win) <= WINDOWS - 1 && int'(rx_win) <= WINDOWS - 1); // R4

  AST_OVF_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idx_ovf |=> cfg_err); // R4

  AST_BADCHAN_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chan_bad |=> cfg_err); // R8

  AST_CLR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !cfg_err); // R1

  AST_AUTOINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_w1 && tx_ainc) |=> int'(tx_win) ==
      ((int'($past(tx_win)) == WINDOWS - 1) ? 0 : int'($past(tx_win)) + 1)); // R6

  AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(scan_slot)); // R10

  AST_SCAN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    scan_wrap |=> scan_slot == '0); // R10

  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(scan_slot) < ENTRIES); // R10

  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && !clr) |=> acc_rvalid); // R11

  AST_READ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_wr && !clr) |=> !acc_rvalid); // R12

endmodule

bind cal_window_table cal_window_table_chk #(
  .WINDOWS (WINDOWS),
  .WIN_W   (WIN_W),
  .ENTRIES (ENTRIES),
  .ENT_W   (ENT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr         (clr),
  .acc_en      (acc_en),
  .acc_wr      (acc_wr),
  .acc_rvalid  (acc_rvalid),
  .cfg_err     (cfg_err),
  .ev_idx_ovf  (ev_idx_ovf),
  .ev_chan_bad (ev_chan_bad),
  .tx_w1       (ev_w1_wr[0]),
  .tx_ainc     (tbl_ainc[0]),
  .tx_win      (tbl_win[0]),
  .rx_win      (tbl_win[1]),
  .scan_en     (scan_en),
  .scan_slot   (scan_slot),
  .scan_wrap   (scan_wrap)
);

// File: tb/cal_window_table_test.sv
module cal_window_table_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0, acc_tbl = 1'b0;
  logic [1:0]  acc_addr = 2'd0;
  logic [63:0] acc_wdata = '0;
  logic [63:0] acc_rdata;
  logic        acc_rvalid, cfg_err;
  logic        scan_en = 1'b0;
  logic [9:0]  scan_len = 10'd4;
  logic [8:0]  scan_slot;
  logic        scan_round;
  logic [1:0]  tx_slot_ctl, rx_slot_ctl;
  logic [7:0]  tx_slot_id, rx_slot_id;

  int checks = 0;
  int errors = 0;

  logic [63:0] exp_q [$];
  string       tag_q [$];
  logic [63:0] mon_e;
  string       mon_t;

  always #2 clk = ~clk;

  cal_window_table uut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_tbl(acc_tbl), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
    .cfg_err(cfg_err), .scan_en(scan_en), .scan_len(scan_len),
    .scan_slot(scan_slot), .scan_round(scan_round),
    .tx_slot_ctl(tx_slot_ctl), .tx_slot_id(tx_slot_id),
    .rx_slot_ctl(rx_slot_ctl), .rx_slot_id(rx_slot_id)
  );

  // Lane k of a data word: ID in [16k+7:16k], code in [16k+9:16k+8].
  function automatic logic [63:0] ent(input int k, input logic [1:0] c, input logic [7:0] id);
    logic [63:0] r;
    r = '0;
    r[16*k +: 8]     = id;
    r[16*k + 8 +: 2] = c;
    return r;
  endfunction

  function automatic logic [63:0] fill4(input logic [1:0] c);
    return ent(0, c, 8'h0) | ent(1, c, 8'h0) | ent(2, c, 8'h0) | ent(3, c, 8'h0);
  endfunction

  function automatic logic [63:0] chan_cmd(input int ch, input logic [7:0] id);
    return (64'(id) << 16) | 64'(ch);
  endfunction

  // Monitor: compares each returned read against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && acc_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11/R12 unexpected read data: actual %h expected no data", acc_rdata);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        if (acc_rdata !== mon_e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", mon_t, acc_rdata, mon_e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic tbl, input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_tbl = tbl; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic tbl, input logic [1:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    acc_en = 1'b1; acc_wr = 1'b0; acc_tbl = tbl; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      scan_en = 1'b1;
      @(negedge clk);
      scan_en = 1'b0;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  logic [63:0] pat_a, pat_b;

  initial begin
    pat_a = ent(0, 2'd0, 8'h11) | ent(1, 2'd1, 8'h22) | ent(2, 2'd2, 8'h33) | ent(3, 2'd3, 8'h44);
    pat_b = ent(0, 2'd3, 8'h55) | ent(1, 2'd2, 8'h66) | ent(2, 2'd1, 8'h77) | ent(3, 2'd0, 8'h88);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R1 cfg_err after reset", 64'(cfg_err), 64'd0);
    chk("R10 slot after reset", 64'(scan_slot), 64'd0);
    chk("R10 round flag at slot 0", 64'(scan_round), 64'd1);
    rd(0, 2'd0, 64'h0, "R3 tx index after reset");
    rd(0, 2'd1, fill4(2'd3), "R1 tx word0 XOFF");
    rd(1, 2'd2, fill4(2'd2), "R1 rx word1 XON");

    // Window writes, padding bits dropped, auto-increment
    wr(0, 2'd0, 64'h102);
    wr(0, 2'd1, pat_a | 64'hFC00_FC00_FC00_FC00);
    rd(0, 2'd0, 64'h102, "R6 word0 write keeps index");
    rd(0, 2'd1, pat_a, "R2 R5 word0 contents");
    wr(0, 2'd2, pat_b);
    rd(0, 2'd0, 64'h103, "R6 word1 write advances index");
    wr(0, 2'd0, 64'h002);
    rd(0, 2'd2, pat_b, "R5 word1 contents");
    rd(0, 2'd0, 64'h002, "R5 read keeps index");
    rd(1, 2'd1, fill4(2'd2), "R9 rx untouched by tx writes");

    // Wrap at the last window
    wr(0, 2'd0, 64'h100 | 64'd35);
    wr(0, 2'd2, pat_a);
    rd(0, 2'd0, 64'h100, "R6 index wraps 35 to 0");
    chk("R4 no error before overflow", 64'(cfg_err), 64'd0);

    // Saturation
    wr(0, 2'd0, 64'd40);
    chk("R4 overflow sets cfg_err", 64'(cfg_err), 64'd1);
    rd(0, 2'd0, 64'd35, "R4 index saturates at 35");

    // Clear
    wr(0, 2'd0, 64'd2);
    pulse_clr();
    chk("R1 clr drops cfg_err", 64'(cfg_err), 64'd0);
    rd(0, 2'd1, fill4(2'd3), "R1 tx window 2 back to XOFF");
    rd(0, 2'd0, 64'd2, "R1 clr keeps index");

    // Channel commands on the receive table
    wr(1, 2'd0, 64'd4);
    wr(1, 2'd3, chan_cmd(14, 8'h9A));
    wr(1, 2'd0, 64'd1);
    rd(1, 2'd2, ent(0, 2'd2, 0) | ent(1, 2'd2, 0) | ent(2, 2'd2, 0) | ent(3, 2'd0, 8'h9A),
       "R7 channel 14 at slot 15");
    rd(1, 2'd1, fill4(2'd2), "R7 odd window keeps position 0");
    wr(1, 2'd3, chan_cmd(15, 8'h3C));
    wr(1, 2'd0, 64'd2);
    rd(1, 2'd1, ent(0, 2'd1, 0) | ent(1, 2'd0, 8'h3C) | ent(2, 2'd2, 0) | ent(3, 2'd2, 0),
       "R7 channel 15 at slot 17 with link slot 16");
    wr(1, 2'd0, 64'd35);
    wr(1, 2'd3, chan_cmd(269, 8'h77));
    rd(1, 2'd0, 64'd35, "R7 channel command keeps index");
    rd(1, 2'd2, ent(0, 2'd2, 0) | ent(1, 2'd2, 0) | ent(2, 2'd2, 0) | ent(3, 2'd0, 8'h77),
       "R7 channel 269 at slot 287");
    chk("R8 no error for valid channels", 64'(cfg_err), 64'd0);
    wr(1, 2'd3, chan_cmd(270, 8'hEE));
    chk("R8 channel 270 sets cfg_err", 64'(cfg_err), 64'd1);
    rd(1, 2'd2, ent(0, 2'd2, 0) | ent(1, 2'd2, 0) | ent(2, 2'd2, 0) | ent(3, 2'd0, 8'h77),
       "R8 channel 270 changes nothing");
    wr(0, 2'd0, 64'd2);
    rd(0, 2'd1, fill4(2'd3), "R9 tx untouched by rx channel commands");

    // Scanner, short round
    scan_len = 10'd4;
    step(3);
    chk("R10 slot after 3 steps", 64'(scan_slot), 64'd3);
    chk("R10 round low off slot 0", 64'(scan_round), 64'd0);
    step(1);
    chk("R10 wrap at length 4", 64'(scan_slot), 64'd0);
    chk("R10 round flag after wrap", 64'(scan_round), 64'd1);

    // Round of 18 across the first group boundary
    scan_len = 10'd18;
    step(16);
    chk("R10 rx code at link slot 16", 64'(rx_slot_ctl), 64'd1);
    chk("R10 tx code at slot 16", 64'(tx_slot_ctl), 64'd3);
    step(1);
    chk("R10 rx code at slot 17", 64'(rx_slot_ctl), 64'd0);
    chk("R10 rx id at slot 17", 64'(rx_slot_id), 64'h3C);
    step(1);
    chk("R10 wrap at length 18", 64'(scan_slot), 64'd0);

    // Full round via length 0
    scan_len = 10'd0;
    step(287);
    chk("R10 last slot of full round", 64'(scan_slot), 64'd287);
    chk("R10 rx id at slot 287", 64'(rx_slot_id), 64'h77);
    step(1);
    chk("R10 full round wraps", 64'(scan_slot), 64'd0);
    chk("R10 round flag full round", 64'(scan_round), 64'd1);

    // Access in a clear cycle is dropped
    wr(0, 2'd0, 64'd7);
    @(negedge clk);
    clr = 1'b1; acc_en = 1'b1; acc_wr = 1'b1; acc_tbl = 1'b0; acc_addr = 2'd0; acc_wdata = 64'd9;
    @(negedge clk);
    acc_wr = 1'b0;
    @(negedge clk);
    clr = 1'b0; acc_en = 1'b0;
    chk("R12 read in clear cycle gives no data", 64'(acc_rvalid), 64'd0);
    rd(0, 2'd0, 64'd7, "R12 write in clear cycle dropped");
    rd(1, 2'd3, 64'd0, "R11 address 3 reads 0");
    rd(1, 2'd2, fill4(2'd2), "R1 rx cleared to XON");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 missing read data: actual %0d pending expected 0", exp_q.size());
    end
    summary();
  end

endmodule